// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port with Interrupt Sensitivity

The block is a general-purpose I/O port of `WIDTH` pins (16 by default) that sits behind a simple single-cycle register bus. Software uses a direction register to make each pin an input or an output. Software then changes output levels in one of two ways: by writing the output register directly, or through write-one-to-modify strobes that set, clear or toggle any chosen group of bits. Bits written as zero keep their level. A single write can select several modify operations at once. The low three address bits act as a bitmap of set, clear and toggle, and a fixed priority settles any conflict between them.

Every pin can also raise an interrupt. Each pin has an interrupt source. For an input pin the source is the pin level after a two-flop synchronizer. For an output pin the source is the output register, so software can trigger an interrupt by driving the pin. Each pin has its own sensitivity: level, rising edge, or both edges. A level pin reports pending for as long as its source is high. An edge pin latches the event until software clears it. Set and clear registers control a per-pin enable mask, and the pending, enabled pins are ORed into one request line.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset, the output register, direction, mask, sensitivity and edge-select registers are all zero, so `pin_oe`, `pin_out` and `irq` are low.
- R2: Address 0x8 holds the direction register. A bit of 1 makes that pin an output, `pin_oe` equals this register, and a read at 0x8 returns it.
- R3: A write to address 0 loads the output register directly. A write to addresses 1 to 7 treats address bit 0 as set, bit 1 as clear and bit 2 as toggle. Each selected operation acts on the data bits written as 1, and bits written as 0 keep their level. The result appears on `pin_out` the cycle after the write. Reads at 1 to 7 return zero.
- R4: When one write selects several modify operations, clear wins over set, and set wins over toggle, for each bit.
- R5: A read at address 0 returns, for each pin, the output register when the pin is an output. For an input pin it returns the pin level after two clock edges of synchronization.
- R6: Writing 1s at address 0x9 enables those pins' interrupts, and writing 1s at 0xA disables them. A read at 0x9 returns the mask.
- R7: Address 0xB selects sensitivity per pin, with 0 for level and 1 for edge. A level pin is pending exactly while its source is high and is never latched.
- R8: An edge pin with its bit at 0 in the edge-select register at 0xC latches pending on a rising source edge only. A falling edge has no effect.
- R9: An edge pin with its bit at 1 at 0xC latches pending on both rising and falling source edges.
- R10: A latched edge event stays pending until a modify write that selects clear (address bit 1 set) carries a 1 in that pin's bit. That write removes it the following cycle.
- R11: The interrupt source of an output pin is its output register, so a software write that raises an edge-mode output bit makes that pin pending.
- R12: `irq` is the OR of all pending pins whose mask bit is 1. A read at 0xD returns the pending bits whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output register levels |
| pin_oe | output | 16 | Output enables (direction register) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an edge pin after its latch has been cleared while the source stays high. The stimulus raises the pin, waits out the synchronizer and latch stages, clears the latch through the bus, and only then lowers the pin. Whether a falling edge re-arms the request then shows whether rising-only and both-edge selection are kept apart. Output-pin interrupts are reached only through bus writes, so the port's own set strobe is the stimulus that creates the edge.

// File: rtl/gpio_pkg.sv
// Package: register addresses shared by the GPIO port blocks.
// Assumes a 4-bit address bus. Addresses 1..7 form a bitmap of
// modify operations: bit0 set, bit1 clear, bit2 toggle.
package gpio_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_DATA  = 4'h0;
    localparam logic [ADDR_W-1:0] A_DIR   = 4'h8;
    localparam logic [ADDR_W-1:0] A_MSET  = 4'h9;
    localparam logic [ADDR_W-1:0] A_MCLR  = 4'hA;
    localparam logic [ADDR_W-1:0] A_SENSE = 4'hB;
    localparam logic [ADDR_W-1:0] A_BOTH  = 4'hC;
    localparam logic [ADDR_W-1:0] A_PEND  = 4'hD;
    localparam int OP_SET = 0;
    localparam int OP_CLR = 1;
    localparam int OP_TGL = 2;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for asynchronous pin inputs.
// Assumes STAGES >= 1. Resets every stage to zero.
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the pin levels one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else if (g == 0) stage[g] <= d;
                else stage[g] <= stage[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Module: bus-visible registers of the GPIO port.
// Holds the output, direction, mask, sensitivity and edge-select
// registers, decodes the modify bitmap writes with priority
// clear > set > toggle, and drives the combinational read mux.
// Assumes one bus access per cycle; reads have no side effects.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  sync_in,
    input  logic [WIDTH-1:0]  pend,
    output logic [WIDTH-1:0]  out_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  mask_q,
    output logic [WIDTH-1:0]  sense_q,
    output logic [WIDTH-1:0]  both_q,
    output logic [WIDTH-1:0]  clr_strobe,
    output logic [WIDTH-1:0]  bus_rdata
);
    logic             mod_wr;
    logic [WIDTH-1:0] set_bits, clr_bits, tgl_bits, out_mod;

    // Decode a modify write and its selected operations.
    always_comb begin
        mod_wr   = bus_wr && !bus_addr[3] && (bus_addr[2:0] != 3'b000);
        set_bits = (mod_wr && bus_addr[OP_SET]) ? bus_wdata : '0;
        clr_bits = (mod_wr && bus_addr[OP_CLR]) ? bus_wdata : '0;
        tgl_bits = (mod_wr && bus_addr[OP_TGL]) ? bus_wdata : '0;
        out_mod  = ((out_q ^ (tgl_bits & ~set_bits)) | set_bits) & ~clr_bits;
    end

    assign clr_strobe = clr_bits;

    // Update the output register from direct or modify writes.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else if (bus_wr && bus_addr == A_DATA) out_q <= bus_wdata;
        else if (mod_wr) out_q <= out_mod;
    end

    // Hold the configuration registers and the interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            mask_q  <= '0;
            sense_q <= '0;
            both_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_DIR:   dir_q   <= bus_wdata;
                A_MSET:  mask_q  <= mask_q | bus_wdata;
                A_MCLR:  mask_q  <= mask_q & ~bus_wdata;
                A_SENSE: sense_q <= bus_wdata;
                A_BOTH:  both_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Select read data by address.
    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = (dir_q & out_q) | (~dir_q & sync_in);
            A_DIR:   bus_rdata = dir_q;
            A_MSET:  bus_rdata = mask_q;
            A_SENSE: bus_rdata = sense_q;
            A_BOTH:  bus_rdata = both_q;
            A_PEND:  bus_rdata = pend;
            default: bus_rdata = '0;
        endcase
    end

    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_wr && bus_addr[OP_CLR]) |=> ((out_q & $past(bus_wdata)) == '0));
    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_wr && bus_addr[OP_SET] && !bus_addr[OP_CLR])
        |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata)));
    // R3
    untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_wr |=> (((out_q ^ $past(out_q)) & ~$past(bus_wdata)) == '0));
    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MSET)
        |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
endmodule

// File: rtl/gpio_irq.sv
// Module: per-pin interrupt detection and combining.
// Detects edges on the interrupt source, latches them for edge pins,
// passes the source through for level pins, and ORs enabled pending
// bits into one request. Assumes the source is already synchronous.
module gpio_irq #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src,
    input  logic [WIDTH-1:0] sense,
    input  logic [WIDTH-1:0] both,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] pend,
    output logic             irq
);
    logic [WIDTH-1:0] src_q, latch_q, edge_hit;

    // Remember the source from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else src_q <= src;
    end

    // Find qualifying edges for pins in edge mode.
    always_comb begin
        edge_hit = sense & ((src & ~src_q) | (both & ~src & src_q));
    end

    // Latch edge events; a clear strobe drops them, a new edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else latch_q <= ((latch_q & ~clr) | edge_hit) & sense;
    end

    // Combine latched and level pending bits into the request.
    always_comb begin
        pend = (sense & latch_q) | (~sense & src);
        irq  = |(pend & mask);
    end

    // R12
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
    // R8
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & $past(edge_hit)) == $past(edge_hit)));
    // R10
    clear_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> ((latch_q & $past(clr & ~edge_hit)) == '0));
endmodule

// File: rtl/gpio_port_ctl.sv
// Module: top of the GPIO port. Connects the pin synchronizer, the
// register file and the interrupt logic. The interrupt source of a
// pin is its output register when it is an output, else its
// synchronized level. Assumes a synchronous active-low reset.
module gpio_port_ctl
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);
    logic [WIDTH-1:0] sync_in, out_q, dir_q, mask_q, sense_q, both_q;
    logic [WIDTH-1:0] clr_strobe, pend, src;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_in)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .sync_in(sync_in), .pend(pend),
        .out_q(out_q), .dir_q(dir_q), .mask_q(mask_q), .sense_q(sense_q),
        .both_q(both_q), .clr_strobe(clr_strobe), .bus_rdata(bus_rdata)
    );

    // Pick the interrupt source per pin by direction.
    always_comb begin
        src = (dir_q & out_q) | (~dir_q & sync_in);
    end

    gpio_irq #(.WIDTH(WIDTH)) u_irq (
        .clk(clk), .rst_n(rst_n), .src(src), .sense(sense_q),
        .both(both_q), .mask(mask_q), .clr(clr_strobe),
        .pend(pend), .irq(irq)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    // R2
    oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIR) |=> (pin_oe == $past(bus_wdata)));
endmodule

// File: tb/gpio_port_ctl_tb.sv
module gpio_port_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    gpio_port_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {write addr, write data, read addr, expected read}
    localparam int NV = 13;
    localparam logic [39:0] VEC [NV] = '{
        {4'h8, 16'hFFFF, 4'h8, 16'hFFFF},  // R2 all outputs
        {4'h0, 16'hA5A5, 4'h0, 16'hA5A5},  // R3 direct load
        {4'h1, 16'h000F, 4'h0, 16'hA5AF},  // R3 set
        {4'h2, 16'h00F0, 4'h0, 16'hA50F},  // R3 clear
        {4'h4, 16'hFF00, 4'h0, 16'h5A0F},  // R3 toggle
        {4'h3, 16'h0003, 4'h0, 16'h5A0C},  // R4 clear over set
        {4'h5, 16'h0030, 4'h0, 16'h5A3C},  // R4 set over toggle
        {4'h6, 16'h0C00, 4'h0, 16'h523C},  // R4 clear over toggle
        {4'h7, 16'hF000, 4'h0, 16'h023C},  // R4 clear over all
        {4'h9, 16'h00FF, 4'h9, 16'h00FF},  // R6 mask set
        {4'hA, 16'h000F, 4'h9, 16'h00F0},  // R6 mask clear
        {4'hB, 16'h1234, 4'hB, 16'h1234},  // R7 sense readback
        {4'hC, 16'h4321, 4'hC, 16'h4321}   // R9 edge select readback
    };

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_in = '0;
        tick(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] r;
        do_reset();
        // R1 reset state
        check("R1 oe", pin_oe, 16'h0);
        check("R1 out", pin_out, 16'h0);
        check("R1 irq", {15'b0, irq}, 16'h0);

        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][39:36], VEC[v][35:20]);
            rd(VEC[v][19:16], r);
            check($sformatf("R3 vector %0d", v), r, VEC[v][15:0]);
        end
        check("R2 oe", pin_oe, 16'hFFFF);
        check("R3 pins", pin_out, 16'h023C);
        rd(4'h1, r);
        check("R3 strobe reads zero", r, 16'h0);

        do_reset();
        // R1 registers clear after reset
        rd(4'h8, r); check("R1 dir", r, 16'h0);
        rd(4'h9, r); check("R1 mask", r, 16'h0);
        rd(4'hB, r); check("R1 sense", r, 16'h0);
        rd(4'hC, r); check("R1 both", r, 16'h0);
        check("R1 out after reset", pin_out, 16'h0);

        // R5 input synchronization latency and mixed directions
        @(negedge clk); pin_in = 16'h00C3;
        tick(1); rd(4'h0, r); check("R5 one edge", r, 16'h0000);
        tick(1); rd(4'h0, r); check("R5 two edges", r, 16'h00C3);
        wr(4'h8, 16'h00F0);
        wr(4'h1, 16'h00A0);
        rd(4'h0, r); check("R5 mixed", r, 16'h00A3);

        do_reset();
        // R7 level sensitivity
        wr(4'h9, 16'h0001);
        @(negedge clk); pin_in = 16'h0001;
        tick(2);
        check("R7 level irq", {15'b0, irq}, 16'h1);
        rd(4'hD, r); check("R7 pend", r, 16'h0001);
        pin_in = 16'h0000;
        tick(2);
        check("R7 level not latched", {15'b0, irq}, 16'h0);

        // R8 rising edge only
        wr(4'hB, 16'h0002);
        wr(4'h9, 16'h0002);
        @(negedge clk); pin_in = 16'h0002;
        tick(2); check("R8 before latch", {15'b0, irq}, 16'h0);
        tick(1); check("R8 rise latched", {15'b0, irq}, 16'h1);
        wr(4'h2, 16'h0002);
        check("R10 cleared", {15'b0, irq}, 16'h0);
        pin_in = 16'h0000;
        tick(4); check("R8 fall ignored", {15'b0, irq}, 16'h0);

        // R9 both edges
        wr(4'hC, 16'h0002);
        pin_in = 16'h0002;
        tick(4); check("R9 rise", {15'b0, irq}, 16'h1);
        wr(4'h2, 16'h0002);
        check("R10 clear again", {15'b0, irq}, 16'h0);
        pin_in = 16'h0000;
        tick(4); check("R9 fall", {15'b0, irq}, 16'h1);
        wr(4'h2, 16'h0002);

        // R12 mask gates irq, pending still visible
        wr(4'hA, 16'h0002);
        pin_in = 16'h0002;
        tick(4); check("R12 masked", {15'b0, irq}, 16'h0);
        rd(4'hD, r); check("R12 pend visible", r, 16'h0002);
        wr(4'h9, 16'h0002);
        check("R12 unmasked", {15'b0, irq}, 16'h1);

        do_reset();
        // R11 software-driven output pin interrupt
        wr(4'h8, 16'h0004);
        wr(4'hB, 16'h0004);
        wr(4'h9, 16'h0004);
        check("R11 idle", {15'b0, irq}, 16'h0);
        wr(4'h1, 16'h0004);
        tick(2);
        check("R11 output irq", {15'b0, irq}, 16'h1);
        check("R2 oe port", pin_oe, 16'h0004);
        check("R11 pin out", pin_out, 16'h0004);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule